// File: doc/BRIEF.md
# Lane Execution Mask Save-and-Update Unit

This block holds the 64-bit lane execution mask of a scalar unit and carries out the family of save-and-modify operations on it. When an operation is accepted, the mask value it found is returned as the destination result, and the mask is replaced by one of eight bitwise combinations of a 64-bit source operand with that old mask. A condition flag reports whether any lane is still active after the update.

A separate restore input overwrites the mask outright, for example when diverged control flow re-joins and a stacked mask must come back. Restore has priority over an operation offered in the same cycle, and the operation is then discarded. All outputs are registered. An operation in every cycle is supported, and each one works on the mask the previous one wrote.

Top module: `lane_mask_unit`

## Requirements
- R1: One cycle after an accepted operation (`op_valid` high and `restore_valid` low at a clock edge), `saved_mask` equals the mask as it stood before that operation, and `res_valid` is high for exactly that one cycle.
- R2: With S the source and M the old mask, the new mask for `op_sel` is: 0 S&M, 1 S|M, 2 S^M, 3 S&~M, 4 S|~M, 5 ~(S&M), 6 ~(S|M), 7 ~(S^M).
- R3: After an accepted operation, `scc` is 1 exactly when the new mask is nonzero. Only accepted operations change `scc`.
- R4: Operations in consecutive cycles chain: each one combines with the mask that the operation one cycle earlier produced.
- R5: After reset the mask is all ones, and `saved_mask`, `scc` and `res_valid` are zero.
- R6: When `restore_valid` is high at an edge, the mask takes `restore_mask`. An operation in the same cycle is dropped: `saved_mask` and `scc` keep their values and `res_valid` stays low.
- R7: In a cycle with neither input valid, the mask, `saved_mask` and `scc` keep their values, whatever `op_sel` and `op_src` carry.
- R8: An operation that clears every lane gives `scc` = 0. Later operations still act on the all-zero mask, so a NOR with a zero source brings back all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A save-and-modify operation is offered |
| op_sel | input | 3 | Operation code (see R2) |
| op_src | input | 64 | Source operand |
| restore_valid | input | 1 | Overwrite the mask from `restore_mask` |
| restore_mask | input | 64 | Mask value to restore |
| saved_mask | output | 64 | Mask before the last accepted operation |
| cur_mask | output | 64 | Current execution mask |
| scc | output | 1 | Any lane active after the last accepted operation |
| res_valid | output | 1 | `saved_mask` and `scc` were updated on the last edge |

## Verification
A wrong mask register cannot stay hidden. `cur_mask` shows it at once, and the next accepted operation carries it into `saved_mask` one cycle later, and usually into `scc` as well. A mis-decoded operation code shows up one cycle after that code is used, but only for source and mask patterns where the two functions differ, so each code is driven with many random operands. A wrong restore priority shows at `res_valid` and `saved_mask` on the cycle after the collision.

// File: rtl/lmask_pkg.sv
package lmask_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_AND   = 3'd0,
    SEL_OR    = 3'd1,
    SEL_XOR   = 3'd2,
    SEL_ANDN2 = 3'd3,
    SEL_ORN2  = 3'd4,
    SEL_NAND  = 3'd5,
    SEL_NOR   = 3'd6,
    SEL_XNOR  = 3'd7
  } lmask_sel_e;

  typedef enum logic [1:0] {
    BASE_AND = 2'd0,
    BASE_OR  = 2'd1,
    BASE_XOR = 2'd2
  } lmask_base_e;

  // Each code is split into a base gate, an optional inversion of the old
  // mask on the way in, and an optional inversion of the result.
  typedef struct packed {
    lmask_base_e base;
    logic        inv_mask;
    logic        inv_out;
  } lmask_ctl_t;

  function automatic lmask_ctl_t decode_sel(input logic [SEL_W-1:0] sel);
    lmask_ctl_t c;
    c = '{base: BASE_AND, inv_mask: 1'b0, inv_out: 1'b0};
    case (lmask_sel_e'(sel))
      SEL_AND:   c.base = BASE_AND;
      SEL_OR:    c.base = BASE_OR;
      SEL_XOR:   c.base = BASE_XOR;
      SEL_ANDN2: begin c.base = BASE_AND; c.inv_mask = 1'b1; end
      SEL_ORN2:  begin c.base = BASE_OR;  c.inv_mask = 1'b1; end
      SEL_NAND:  begin c.base = BASE_AND; c.inv_out  = 1'b1; end
      SEL_NOR:   begin c.base = BASE_OR;  c.inv_out  = 1'b1; end
      SEL_XNOR:  begin c.base = BASE_XOR; c.inv_out  = 1'b1; end
      default:   c.base = BASE_AND;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lmask_logic.sv
module lmask_logic
  import lmask_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input  lmask_ctl_t        ctl,
  input  logic [MASK_W-1:0] src,
  input  logic [MASK_W-1:0] mask,
  output logic [MASK_W-1:0] res
);

  function automatic logic [MASK_W-1:0] apply_base(input lmask_base_e b,
                                                   input logic [MASK_W-1:0] a,
                                                   input logic [MASK_W-1:0] m);
    case (b)
      BASE_OR:  return a | m;
      BASE_XOR: return a ^ m;
      default:  return a & m;
    endcase
  endfunction

  logic [MASK_W-1:0] mask_in;
  logic [MASK_W-1:0] raw;

  always_comb begin
    mask_in = ctl.inv_mask ? ~mask : mask;
    raw     = apply_base(ctl.base, src, mask_in);
    res     = ctl.inv_out ? ~raw : raw;
  end

endmodule

// File: rtl/lmask_nonzero.sv
module lmask_nonzero #(
  parameter int MASK_W = 64,
  parameter int CHUNK  = 8
) (
  input  logic [MASK_W-1:0] vec,
  output logic              any_set
);

  localparam int NCHUNK = (MASK_W + CHUNK - 1) / CHUNK;
  localparam int PAD_W  = NCHUNK * CHUNK;

  logic [PAD_W-1:0]  padded;
  logic [NCHUNK-1:0] chunk_set;

  always_comb begin
    padded             = '0;
    padded[MASK_W-1:0] = vec;
  end

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk_set[g] = |padded[g*CHUNK +: CHUNK];
  end

  assign any_set = |chunk_set;

endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
  import lmask_pkg::*;
#(
  parameter int MASK_W   = 64,
  parameter int NZ_CHUNK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic [MASK_W-1:0] op_src,
  input  logic              restore_valid,
  input  logic [MASK_W-1:0] restore_mask,
  output logic [MASK_W-1:0] saved_mask,
  output logic [MASK_W-1:0] cur_mask,
  output logic              scc,
  output logic              res_valid
);

  logic [MASK_W-1:0] mask_q;
  logic [MASK_W-1:0] saved_q;
  logic              scc_q;
  logic              vld_q;

  // Named internal events
  logic              op_fire;
  logic              restore_fire;
  lmask_ctl_t        op_ctl;
  logic [MASK_W-1:0] next_mask;
  logic              next_nonzero;

  assign restore_fire = restore_valid;
  assign op_fire      = op_valid & ~restore_valid;
  assign op_ctl       = decode_sel(op_sel);

  lmask_logic #(.MASK_W(MASK_W)) u_logic (
    .ctl  (op_ctl),
    .src  (op_src),
    .mask (mask_q),
    .res  (next_mask)
  );

  lmask_nonzero #(.MASK_W(MASK_W), .CHUNK(NZ_CHUNK)) u_nz (
    .vec     (next_mask),
    .any_set (next_nonzero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      saved_q <= '0;
      scc_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= op_fire;
      if (restore_fire) begin
        mask_q <= restore_mask;
      end else if (op_fire) begin
        mask_q  <= next_mask;
        saved_q <= mask_q;
        scc_q   <= next_nonzero;
      end
    end
  end

  assign saved_mask = saved_q;
  assign cur_mask   = mask_q;
  assign scc        = scc_q;
  assign res_valid  = vld_q;

endmodule

// File: rtl/lane_mask_unit_chk.sv
module lane_mask_unit_chk #(
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              restore_valid,
  input logic [MASK_W-1:0] restore_mask,
  input logic [MASK_W-1:0] saved_mask,
  input logic [MASK_W-1:0] cur_mask,
  input logic              scc,
  input logic              res_valid,
  input logic              op_fire,
  input logic [MASK_W-1:0] next_mask
);

  AST_SAVE_OLD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !restore_valid) |=> (res_valid && saved_mask == $past(cur_mask))); // R1

  AST_MASK_FROM_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> cur_mask == $past(next_mask)); // R2

  AST_SCC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (scc == (cur_mask != '0))); // R3

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> cur_mask == $past(restore_mask)); // R6

  AST_RESTORE_DROPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> (!res_valid && $stable(saved_mask) && $stable(scc))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !restore_valid) |=>
      ($stable(cur_mask) && $stable(saved_mask) && $stable(scc) && !res_valid)); // R7

endmodule

bind lane_mask_unit lane_mask_unit_chk #(.MASK_W(MASK_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .restore_valid (restore_valid),
  .restore_mask  (restore_mask),
  .saved_mask    (saved_mask),
  .cur_mask      (cur_mask),
  .scc           (scc),
  .res_valid     (res_valid),
  .op_fire       (op_fire),
  .next_mask     (next_mask)
);

// File: tb/tb_lane_mask_unit.sv
module tb_lane_mask_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [2:0]   op_sel = '0;
  logic [W-1:0] op_src = '0;
  logic         restore_valid = 1'b0;
  logic [W-1:0] restore_mask = '0;
  logic [W-1:0] saved_mask;
  logic [W-1:0] cur_mask;
  logic         scc;
  logic         res_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] m_mask = '1;
  logic [W-1:0] m_saved = '0;
  logic         m_scc = 1'b0;
  logic         m_vld = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_mask_unit dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_sel        (op_sel),
    .op_src        (op_src),
    .restore_valid (restore_valid),
    .restore_mask  (restore_mask),
    .saved_mask    (saved_mask),
    .cur_mask      (cur_mask),
    .scc           (scc),
    .res_valid     (res_valid)
  );

  function automatic logic [W-1:0] ref_combine(input int code,
                                               input logic [W-1:0] s,
                                               input logic [W-1:0] m);
    case (code)
      0: return s & m;
      1: return s | m;
      2: return s ^ m;
      3: return s & ~m;
      4: return s | ~m;
      5: return ~(s & m);
      6: return ~(s | m);
      default: return ~(s ^ m);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 saved_mask", saved_mask, m_saved);
    chk("R1 res_valid", {63'd0, res_valid}, {63'd0, m_vld});
    chk("R2 cur_mask", cur_mask, m_mask);
    chk("R3 scc", {63'd0, scc}, {63'd0, m_scc});
  endtask

  // Drive one cycle from a falling edge, advance the model, compare at the next falling edge.
  task automatic step(input bit ov, input int code, input logic [W-1:0] s,
                      input bit rv, input logic [W-1:0] rm);
    logic [W-1:0] nm;
    op_valid = ov; op_sel = code[2:0]; op_src = s;
    restore_valid = rv; restore_mask = rm;
    if (rv) begin
      m_mask = rm; m_vld = 1'b0;
    end else if (ov) begin
      nm = ref_combine(code, s, m_mask);
      m_saved = m_mask; m_mask = nm; m_scc = (nm != 0); m_vld = 1'b1;
    end else begin
      m_vld = 1'b0;
    end
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset state
    chk("R5 mask all ones", cur_mask, '1);
    chk("R5 saved zero", saved_mask, '0);
    chk("R5 scc zero", {63'd0, scc}, '0);
    chk("R5 res_valid low", {63'd0, res_valid}, '0);

    // R2: every code with several patterns, restoring a known mask first
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 6; k++) begin
        step(1'b0, 0, '0, 1'b1, rnd64());
        step(1'b1, c, rnd64(), 1'b0, '0);
      end
    end

    // R4: chained operations
    step(1'b0, 0, '0, 1'b1, '1);
    step(1'b1, 0, 64'hFF, 1'b0, '0);
    step(1'b1, 1, 64'h100, 1'b0, '0);
    chk("R4 chained mask", cur_mask, 64'h1FF);
    chk("R4 chained saved", saved_mask, 64'hFF);
    step(1'b1, 3, 64'hFFFF, 1'b0, '0);
    chk("R4 andn2 on chained mask", cur_mask, 64'hFE00);

    // R8: all lanes cleared, then recovered
    step(1'b1, 0, 64'h0, 1'b0, '0);
    chk("R8 mask zero", cur_mask, '0);
    chk("R8 scc zero", {63'd0, scc}, '0);
    step(1'b1, 6, 64'h0, 1'b0, '0);
    chk("R8 nor restores ones", cur_mask, '1);
    chk("R8 saved zero mask", saved_mask, '0);
    chk("R8 scc one", {63'd0, scc}, 64'd1);

    // R6: restore collides with an operation
    step(1'b1, 1, '1, 1'b1, 64'hA5);
    chk("R6 restore wins", cur_mask, 64'hA5);
    chk("R6 op dropped valid", {63'd0, res_valid}, '0);
    chk("R6 saved unchanged", saved_mask, '0);
    chk("R6 scc unchanged", {63'd0, scc}, 64'd1);

    // R7: idle with junk on the operand lines
    step(1'b0, 5, 64'hDEAD_BEEF_0000_1234, 1'b0, 64'h1);
    step(1'b0, 2, '1, 1'b0, '0);
    chk("R7 idle mask", cur_mask, 64'hA5);
    chk("R7 idle saved", saved_mask, '0);

    // Random traffic, compared every cycle
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 8), rnd64(),
           ($urandom % 8) == 0, rnd64());
    end
    // zero-rich sources to reach scc = 0 paths (R3, R8)
    for (int i = 0; i < 200; i++) begin
      step(1'b1, int'($urandom % 8), (($urandom % 2) != 0) ? '0 : '1,
           ($urandom % 16) == 0, '0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule